// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit with Saturation Modes

This block multiplies two 16-bit two's-complement operands and adds the product to, or subtracts it from, a 40-bit accumulator. The accumulator is the width of the 32-bit product plus 8 guard bits, so 256 full-scale products can be summed before it overflows. One command is taken per cycle. Each command is qualified by `in_valid` and selects one of four actions: load a 16-bit word, multiply-add, multiply-subtract, or clear. The accumulator register holds the result one clock edge after the command is accepted.

Static mode pins change how the arithmetic behaves. One pin doubles every product, so a Q15 × Q15 product becomes Q31. One pin replaces the single overflowing product (-1 × -1) with the largest positive Q31 value. One pin enables saturation of the accumulator. One pin moves the clip point from the signed 32-bit range to the full signed 40-bit range. A further pin sets whether loaded words are sign-extended. A sticky overflow flag records every overflow, whether or not saturation is enabled, and stays set until it is cleared.

The command port is a valid/ready stream. `in_ready` is held at 1, so the block never applies back-pressure. A command transfers on every rising edge where `in_valid` is 1. The mode pins and `ovf_clr` are plain level controls that are sampled on the same edge.

Top module: `frac_mac`

## Requirements
- R1: While reset is asserted and after its release, `acc` reads 0 and `ovf` reads 0.
- R2: Command op=0 (load) with `sext_en`=1 sets `acc` to `opa` sign-extended to 40 bits. It does not change `ovf`.
- R3: Command op=0 (load) with `sext_en`=0 sets `acc[15:0]` to `opa` and `acc[39:16]` to zero.
- R4: Command op=1 (multiply-add) adds the signed product `opa`×`opb` to `acc`. With `sat_en`=0 the result wraps modulo 2^40, so a later cancelling step restores the exact value.
- R5: Command op=2 (multiply-subtract) subtracts the signed product from `acc`. All other rules are the same as for op=1.
- R6: With `frac_en`=1 the product is doubled (shifted left by one bit) before it is accumulated.
- R7: When `frac_en`, `psat_en` and `sat_en` are all 1 and both operands are 0x8000, the product used is 0x7FFFFFFF. If any one of the three is 0, the doubled product is 0x0080000000.
- R8: With `wide_en`=0, an overflow is an exact result outside [-2^31, 2^31-1]. With `sat_en`=1 such a result clips to 0x007FFFFFFF when positive and to 0xFF80000000 when negative.
- R9: With `wide_en`=1, an overflow is an exact result outside [-2^39, 2^39-1]. With `sat_en`=1 such a result clips to 0x7FFFFFFFFF when positive and to 0x8000000000 when negative.
- R10: `ovf` is set one edge after any multiply-add or multiply-subtract that overflows under the active width, with or without saturation. It stays set until a cycle with `ovf_clr`=1. A new overflow in that same cycle wins over the clear.
- R11: Command op=3 (clear) sets `acc` to 0 and leaves `ovf` unchanged.
- R12: `in_ready` is always 1. In a cycle with `in_valid`=0, `acc` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Command valid |
| in_ready | output | 1 | Command ready, always 1 |
| op | input | 2 | 0 load, 1 multiply-add, 2 multiply-subtract, 3 clear |
| opa | input | 16 | First operand, and the word that load writes |
| opb | input | 16 | Second operand |
| frac_en | input | 1 | Double each product |
| psat_en | input | 1 | Force (-1)×(-1) to 0x7FFFFFFF |
| sat_en | input | 1 | Saturate the accumulator on overflow |
| wide_en | input | 1 | Clip at 40 bits instead of 32 bits |
| sext_en | input | 1 | Sign-extend loaded words |
| ovf_clr | input | 1 | Clear the sticky overflow flag |
| acc | output | 40 | Accumulator register |
| ovf | output | 1 | Sticky overflow flag |

## Verification
A wrong accumulator value appears on `acc` at the very next sample after the command, and stays visible because every later result builds on it. A long multiply-add chain therefore exposes an error in the product, the extension or the wrap logic within one command. A wrong overflow decision shows up in two places: as a missing or extra clip value on `acc` when saturation is on, and on the sticky `ovf` pin, which keeps the evidence until the next clear. The bench drives long full-scale chains to reach both 40-bit limits. This lets the guard-bit carry logic be judged at the ports, not only the 32-bit limits.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_MAC  = 2'd1,
    OP_MAS  = 2'd2,
    OP_CLR  = 2'd3
  } mac_op_e;
endpackage

// File: rtl/frac_mac_mult.sv
module frac_mac_mult #(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          frac_en,
  input  logic          psat_en,
  input  logic          sat_en,
  output logic [AW-1:0] prod
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] raw;
  logic [AW-1:0]        ext;
  logic [AW-1:0]        dbl;
  logic                 both_min;
  logic                 force_max;

  always_comb begin
    raw       = $signed(a) * $signed(b);
    ext       = {{(AW-PW){raw[PW-1]}}, raw};
    dbl       = frac_en ? {ext[AW-2:0], 1'b0} : ext;
    both_min  = (a == {1'b1, {(DW-1){1'b0}}}) && (b == {1'b1, {(DW-1){1'b0}}});
    force_max = frac_en && psat_en && sat_en && both_min;
    prod      = force_max ? {{(AW-PW+1){1'b0}}, {(PW-1){1'b1}}} : dbl;
  end

  // R7: with all three modes on, the transient 2^31 product never leaves this stage
  always_comb begin
    if (frac_en && psat_en && sat_en)
      p_no_min_square_r7: assert (prod != {{(AW-PW){1'b0}}, 1'b1, {(PW-1){1'b0}}});
  end

  // R6: a doubled product is even unless it was forced to the maximum
  always_comb begin
    if (frac_en && !force_max)
      p_frac_even_r6: assert (prod[0] == 1'b0);
  end
endmodule

// File: rtl/frac_mac_addsat.sv
module frac_mac_addsat #(
  parameter int AW = 40,
  parameter int NW = 32
) (
  input  logic [AW-1:0] acc_in,
  input  logic [AW-1:0] prod,
  input  logic          sub,
  input  logic          sat_en,
  input  logic          wide_en,
  output logic [AW-1:0] res,
  output logic          ovf
);
  localparam int HW = AW - NW + 2;

  logic signed [AW:0] exact;
  logic [HW-1:0]      top_bits;
  logic               ovf_wide;
  logic               ovf_nar;
  logic               neg;
  logic [AW-1:0]      clip;

  always_comb begin
    if (sub) exact = $signed({acc_in[AW-1], acc_in}) - $signed({prod[AW-1], prod});
    else     exact = $signed({acc_in[AW-1], acc_in}) + $signed({prod[AW-1], prod});
    top_bits = exact[AW:NW-1];
    ovf_wide = exact[AW] ^ exact[AW-1];
    ovf_nar  = !((&top_bits) || !(|top_bits));
    ovf      = wide_en ? ovf_wide : ovf_nar;
    neg      = exact[AW];
    if (wide_en)
      clip = neg ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}};
    else
      clip = neg ? {{(AW-NW+1){1'b1}}, {(NW-1){1'b0}}}
                 : {{(AW-NW+1){1'b0}}, {(NW-1){1'b1}}};
    res = (sat_en && ovf) ? clip : exact[AW-1:0];
  end

  // R8: a saturated narrow result fits the signed narrow range
  always_comb begin
    if (sat_en && !wide_en && ovf)
      p_clip_narrow_r8: assert ((&res[AW-1:NW-1]) || !(|res[AW-1:NW-1]));
  end

  // R9: a saturated wide result sits at one end of the 40-bit range
  always_comb begin
    if (sat_en && wide_en && ovf)
      p_clip_wide_r9: assert (res[AW-2:0] == {(AW-1){~res[AW-1]}});
  end
endmodule

// File: rtl/frac_mac.sv
module frac_mac #(
  parameter int DW = 16,
  parameter int GW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [1:0]          op,
  input  logic [DW-1:0]       opa,
  input  logic [DW-1:0]       opb,
  input  logic                frac_en,
  input  logic                psat_en,
  input  logic                sat_en,
  input  logic                wide_en,
  input  logic                sext_en,
  input  logic                ovf_clr,
  output logic [2*DW+GW-1:0]  acc,
  output logic                ovf
);
  import frac_mac_pkg::*;

  localparam int AW = 2 * DW + GW;
  localparam int NW = 2 * DW;

  mac_op_e       op_e;
  logic [AW-1:0] acc_q;
  logic          ovf_q;
  logic [AW-1:0] prod;
  logic [AW-1:0] sum;
  logic          sum_ovf;
  logic [AW-1:0] acc_d;
  logic          new_ovf;

  assign op_e     = mac_op_e'(op);
  assign in_ready = 1'b1;

  frac_mac_mult #(.DW(DW), .AW(AW)) u_mult (
    .a(opa), .b(opb), .frac_en(frac_en), .psat_en(psat_en),
    .sat_en(sat_en), .prod(prod)
  );

  frac_mac_addsat #(.AW(AW), .NW(NW)) u_addsat (
    .acc_in(acc_q), .prod(prod), .sub(op_e == OP_MAS), .sat_en(sat_en),
    .wide_en(wide_en), .res(sum), .ovf(sum_ovf)
  );

  always_comb begin
    acc_d   = acc_q;
    new_ovf = 1'b0;
    if (in_valid) begin
      unique case (op_e)
        OP_LOAD: acc_d = sext_en ? {{(AW-DW){opa[DW-1]}}, opa} : {{(AW-DW){1'b0}}, opa};
        OP_MAC, OP_MAS: begin
          acc_d   = sum;
          new_ovf = sum_ovf;
        end
        default: acc_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      ovf_q <= (ovf_q && !ovf_clr) || new_ovf;
    end
  end

  assign acc = acc_q;
  assign ovf = ovf_q;

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(acc_q));

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd3) |=> (acc_q == '0));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);

  p_load_no_ovf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd0 && !ovf_q) |=> !ovf_q);
endmodule

// File: tb/frac_mac_bench.sv
module frac_mac_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  op = 2'd0;
  logic [15:0] opa = '0;
  logic [15:0] opb = '0;
  logic        frac_en = 1'b0, psat_en = 1'b0, sat_en = 1'b0, wide_en = 1'b0, sext_en = 1'b0;
  logic        ovf_clr = 1'b0;
  logic [39:0] acc;
  logic        ovf;

  int errors = 0;
  int checks = 0;
  logic [39:0] exp_acc = '0;
  logic        exp_ovf = 1'b0;
  bit          done = 0;

  always #4 clk = ~clk;

  frac_mac u_frac_mac (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .opa(opa), .opb(opb), .frac_en(frac_en), .psat_en(psat_en),
    .sat_en(sat_en), .wide_en(wide_en), .sext_en(sext_en), .ovf_clr(ovf_clr),
    .acc(acc), .ovf(ovf)
  );

  function automatic logic [40:0] model(input logic [1:0] o, input logic [15:0] a,
      input logic [15:0] b, input logic fr, input logic ps, input logic sa,
      input logic wi, input logic sx, input logic [39:0] cur);
    longint p, e, hi, lo, c;
    logic ov;
    logic [39:0] r;
    ov = 1'b0;
    r  = '0;
    case (o)
      2'd0: r = sx ? {{24{a[15]}}, a} : {24'd0, a};
      2'd3: r = '0;
      default: begin
        p = longint'($signed(a)) * longint'($signed(b));
        if (fr) p = p * 2;
        if (fr && ps && sa && a == 16'h8000 && b == 16'h8000) p = 64'sd2147483647;
        c = longint'($signed(cur));
        e = (o == 2'd1) ? c + p : c - p;
        hi = wi ? 64'sd549755813887 : 64'sd2147483647;
        lo = -hi - 1;
        ov = (e > hi) || (e < lo);
        if (sa && ov) r = (e > hi) ? hi[39:0] : lo[39:0];
        else r = e[39:0];
      end
    endcase
    return {ov, r};
  endfunction

  task automatic check(input string req, input logic [39:0] ea, input logic eo);
    checks++;
    if (acc !== ea || ovf !== eo) begin
      errors++;
      $display("FAIL %s: acc=%h ovf=%b expected acc=%h ovf=%b", req, acc, ovf, ea, eo);
    end
  endtask

  // assumes the caller stands at a falling edge
  task automatic cmd(input string req, input logic [1:0] o, input logic [15:0] a,
      input logic [15:0] b, input logic clr);
    logic [40:0] m;
    op = o; opa = a; opb = b; ovf_clr = clr; in_valid = 1'b1;
    m = model(o, a, b, frac_en, psat_en, sat_en, wide_en, sext_en, exp_acc);
    @(negedge clk);
    in_valid = 1'b0; ovf_clr = 1'b0;
    exp_acc = m[39:0];
    exp_ovf = (exp_ovf && !clr) || m[40];
    check(req, exp_acc, exp_ovf);
  endtask

  task automatic idle_clear(input string req);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    exp_ovf = 1'b0;
    check(req, exp_acc, exp_ovf);
  endtask

  task automatic modes(input logic fr, input logic ps, input logic sa, input logic wi,
      input logic sx);
    frac_en = fr; psat_en = ps; sat_en = sa; wide_en = wi; sext_en = sx;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: acc=%h ovf=%b expected acc=%h ovf=%b", acc, ovf, exp_acc, exp_ovf);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check("R1", 40'd0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 40'd0, 1'b0);
    if (in_ready !== 1'b1) begin
      errors++; $display("FAIL R12: in_ready=%b expected 1", in_ready);
    end
    checks++;

    modes(0, 0, 0, 0, 1);
    cmd("R2", 2'd0, 16'h8ABC, 16'h0, 1'b0);
    modes(0, 0, 0, 0, 0);
    cmd("R3", 2'd0, 16'h8ABC, 16'h0, 1'b0);
    repeat (3) @(negedge clk);
    check("R12", exp_acc, exp_ovf);
    cmd("R11", 2'd3, 16'h1234, 16'h5678, 1'b0);
    cmd("R4", 2'd1, 16'd300, 16'hFFF9, 1'b0);
    cmd("R5", 2'd2, 16'd1000, 16'd1000, 1'b0);
    modes(1, 0, 0, 0, 0);
    cmd("R6", 2'd1, 16'h4000, 16'h4000, 1'b0);

    // R7 both ways, starting from zero
    modes(1, 1, 1, 0, 0);
    cmd("R11", 2'd3, 16'h0, 16'h0, 1'b0);
    cmd("R7", 2'd1, 16'h8000, 16'h8000, 1'b0);
    modes(1, 0, 1, 1, 0);
    cmd("R11", 2'd3, 16'h0, 16'h0, 1'b0);
    cmd("R7", 2'd1, 16'h8000, 16'h8000, 1'b0);
    if (acc !== 40'h0080000000) begin
      errors++; $display("FAIL R7: acc=%h expected 0080000000", acc);
    end
    checks++;

    // R8 positive and negative clips in narrow mode
    modes(1, 0, 1, 0, 0);
    cmd("R11", 2'd3, 16'h0, 16'h0, 1'b0);
    cmd("R8", 2'd1, 16'h8000, 16'h8000, 1'b0);
    if (acc !== 40'h007FFFFFFF) begin
      errors++; $display("FAIL R8: acc=%h expected 007FFFFFFF", acc);
    end
    checks++;
    cmd("R10", 2'd2, 16'h0, 16'h0, 1'b0);
    idle_clear("R10");
    cmd("R11", 2'd3, 16'h0, 16'h0, 1'b0);
    cmd("R8", 2'd1, 16'h8000, 16'h7FFF, 1'b0);
    cmd("R8", 2'd1, 16'h8000, 16'h7FFF, 1'b0);
    if (acc !== 40'hFF80000000) begin
      errors++; $display("FAIL R8: acc=%h expected FF80000000", acc);
    end
    checks++;
    // R10: clear with a new overflow in the same cycle keeps the flag
    cmd("R10", 2'd1, 16'h8000, 16'h7FFF, 1'b1);

    // R4 wrap without saturation, then cancel
    modes(1, 0, 0, 1, 0);
    idle_clear("R10");
    cmd("R11", 2'd3, 16'h0, 16'h0, 1'b0);
    for (int i = 0; i < 257; i++) cmd("R4", 2'd1, 16'h8000, 16'h8000, 1'b0);
    for (int i = 0; i < 257; i++) cmd("R4", 2'd2, 16'h8000, 16'h8000, 1'b0);
    if (acc !== 40'd0) begin
      errors++; $display("FAIL R4: acc=%h expected 0000000000", acc);
    end
    checks++;

    // R9 positive and negative clips in wide mode
    modes(1, 0, 1, 1, 0);
    idle_clear("R10");
    for (int i = 0; i < 257; i++) cmd("R9", 2'd1, 16'h8000, 16'h8000, 1'b0);
    if (acc !== 40'h7FFFFFFFFF) begin
      errors++; $display("FAIL R9: acc=%h expected 7FFFFFFFFF", acc);
    end
    checks++;
    cmd("R11", 2'd3, 16'h0, 16'h0, 1'b0);
    idle_clear("R10");
    for (int i = 0; i < 257; i++) cmd("R9", 2'd2, 16'h8000, 16'h8000, 1'b0);
    if (acc !== 40'h8000000000) begin
      errors++; $display("FAIL R9: acc=%h expected 8000000000", acc);
    end
    checks++;

    // constrained random mix
    for (int i = 0; i < 2000; i++) begin
      logic [1:0] o;
      logic [15:0] a, b;
      int k;
      k = $urandom_range(0, 9);
      o = (k < 1) ? 2'd0 : (k < 5) ? 2'd1 : (k < 9) ? 2'd2 : 2'd3;
      a = ($urandom_range(0, 5) == 0) ? 16'h8000 : 16'($urandom);
      b = ($urandom_range(0, 5) == 0) ? 16'h8000 : 16'($urandom);
      modes(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk);
        check("R12", exp_acc, exp_ovf);
      end
      cmd(o == 2'd0 ? "R2" : o == 2'd1 ? "R4" : o == 2'd2 ? "R5" : "R11",
          o, a, b, ($urandom_range(0, 9) == 0));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule